// File: doc/BRIEF.md
# Event-State Page Load Controller

This block keeps a two-bit pending/queued (P/Q) coalescing state for each entry of a small bank of event queue descriptors. Every descriptor carries two independent state fields, one for notification events and one for escalation events. Software reaches them only through loads into a page-mapped region. The load address picks the descriptor, the field and the operation. One load returns a small result and may change the chosen field in the same cycle.

Each descriptor owns a pair of adjacent pages. The even page of the pair acts on the notification field and the odd page acts on the escalation field. Inside a page the low twelve address bits choose one of three operations: end-of-interrupt, read, or force to a fixed value. Stores and accesses of any size other than 8 bytes are refused. Loads to descriptors that do not exist, or that the surrounding logic marks as disabled, return all ones. The result is a 64-bit numeric value, placed on the big-endian data bus unchanged.

Top module: `esb_page_ctrl`

## Requirements
- R1: After reset every field of every descriptor holds P/Q = 01 (P is bit 1, Q is bit 0) and rsp_valid is low.
- R2: The descriptor index is req_addr shifted right by PAGE_SHIFT+1 (13 by default). Address bit PAGE_SHIFT selects the field: 0 is the notification field and 1 is the escalation field. An operation on one field leaves the other field unchanged.
- R3: A load at offset 0x800 to 0xBFF (address bits [11:0]) returns {62'b0, P, Q} and leaves the state unchanged.
- R4: A load at offset 0x000 to 0x7FF is an end-of-interrupt. If Q was 1 it returns 1 and the state becomes 10. If Q was 0 it returns 0 and the state becomes 00.
- R5: A load at offset 0xC00 to 0xFFF returns the previous {P,Q} and sets the field to offset bits [9:8].
- R6: A load whose descriptor index is at or above N_DESC, or whose desc_en bit is 0, returns all ones with rsp_err low and changes no state.
- R7: A store (req_write=1) returns all ones with rsp_err high and changes no state.
- R8: A load with req_size other than 3 (8 bytes) returns all ones with rsp_err high and changes no state.
- R9: A response appears exactly one cycle after each request. A load issued in the cycle after another load sees the state that load left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | log2 of the access size in bytes; only 3 is legal |
| req_addr | input | ADDR_W | Byte address within the region |
| desc_en | input | N_DESC | Per-descriptor valid bit |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Load result |
| rsp_err | output | 1 | Request refused (store or wrong size) |

## Verification
The assertions assume that requests arrive at most once per cycle and that desc_en is steady while a request to that descriptor is being decoded. The bench drives requests only at falling edges and changes desc_en only while reset is held. The response checks rely on every request, legal or not, producing exactly one response. The bench therefore mixes stores, wrong sizes, disabled descriptors and out-of-range indices into the traffic, and never issues a second request in the same cycle.

// File: rtl/esb_pkg.sv
package esb_pkg;

   typedef enum logic [1:0] {
      OP_EOI = 2'd0,
      OP_GET = 2'd1,
      OP_SET = 2'd2
   } esb_op_e;

   localparam logic [1:0] SIZE_8B = 2'd3;

   function automatic esb_op_e op_of(input logic [11:0] off);
      if (!off[11])      return OP_EOI;
      else if (!off[10]) return OP_GET;
      else               return OP_SET;
   endfunction

endpackage

// File: rtl/esb_decode.sv
module esb_decode
   import esb_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int PAGE_SHIFT = 12,
   parameter int N_DESC     = 4,
   parameter int IDX_W      = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              field_sel,
   output esb_op_e           op,
   output logic [1:0]        set_val,
   output logic              known
);
   localparam int SHIFT = PAGE_SHIFT + 1;

   generate
      if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
         $error("esb_decode: PAGE_SHIFT must be 12 or 16");
      end
      if (N_DESC < 1) begin : g_bad_count
         $error("esb_decode: N_DESC must be at least 1");
      end
      if (ADDR_W < SHIFT + IDX_W) begin : g_bad_width
         $error("esb_decode: ADDR_W too narrow for N_DESC page pairs");
      end
   endgenerate

   logic [ADDR_W-1:0] desc_full;
   logic [11:0]       offset;

   always_comb begin
      desc_full = addr >> SHIFT;
      known     = desc_full < ADDR_W'(N_DESC);
      idx       = desc_full[IDX_W-1:0];
      field_sel = addr[PAGE_SHIFT];
      offset    = addr[11:0];
      op        = op_of(offset);
      set_val   = offset[9:8];
   end

endmodule

// File: rtl/esb_pq_alu.sv
module esb_pq_alu
   import esb_pkg::*;
(
   input  esb_op_e    op,
   input  logic [1:0] cur,
   input  logic [1:0] set_val,
   output logic [1:0] nxt,
   output logic [1:0] res
);
   always_comb begin
      unique case (op)
         OP_EOI: begin
            res = {1'b0, cur[0]};
            nxt = cur[0] ? 2'b10 : 2'b00;
         end
         OP_SET: begin
            res = cur;
            nxt = set_val;
         end
         default: begin
            res = cur;
            nxt = cur;
         end
      endcase
   end

   always_comb begin
      if (op == OP_EOI) begin
         assert_eoi_clears_q_R4: assert (nxt[0] == 1'b0 && res[1] == 1'b0);
      end
   end

endmodule

// File: rtl/esb_state_bank.sv
module esb_state_bank #(
   parameter int         N_DESC   = 4,
   parameter int         IDX_W    = 2,
   parameter logic [1:0] RESET_PQ = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             field_sel,
   output logic [1:0]       cur_pq,
   input  logic             wr_en,
   input  logic [1:0]       wr_pq
);
   logic [1:0] pq_ntf [N_DESC];
   logic [1:0] pq_esc [N_DESC];

   always_comb begin
      cur_pq = RESET_PQ;
      for (int k = 0; k < N_DESC; k++) begin
         if (idx == IDX_W'(k)) cur_pq = field_sel ? pq_esc[k] : pq_ntf[k];
      end
   end

   for (genvar i = 0; i < N_DESC; i++) begin : g_desc
      logic hit_i;
      assign hit_i = wr_en && (idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pq_ntf[i] <= RESET_PQ;
            pq_esc[i] <= RESET_PQ;
         end else if (hit_i) begin
            if (field_sel) pq_esc[i] <= wr_pq;
            else           pq_ntf[i] <= wr_pq;
         end
      end

      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && idx == IDX_W'(i)) |=> ($stable(pq_ntf[i]) && $stable(pq_esc[i])));

      assert_other_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && idx == IDX_W'(i) && !field_sel) |=> $stable(pq_esc[i]));
   end

endmodule

// File: rtl/esb_page_ctrl.sv
module esb_page_ctrl
   import esb_pkg::*;
#(
   parameter int         ADDR_W     = 24,
   parameter int         PAGE_SHIFT = 12,
   parameter int         N_DESC     = 4,
   parameter logic [1:0] RESET_PQ   = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [N_DESC-1:0] desc_en,
   output logic              rsp_valid,
   output logic [63:0]       rsp_data,
   output logic              rsp_err
);
   localparam int IDX_W = (N_DESC > 1) ? $clog2(N_DESC) : 1;

   logic [IDX_W-1:0] idx;
   logic             field_sel, known, en_bit, legal, hit, wr_en;
   esb_op_e          op;
   logic [1:0]       set_val, cur_pq, nxt_pq, res;

   esb_decode #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .N_DESC(N_DESC), .IDX_W(IDX_W)
   ) u_decode (
      .addr(req_addr), .idx(idx), .field_sel(field_sel),
      .op(op), .set_val(set_val), .known(known)
   );

   esb_state_bank #(
      .N_DESC(N_DESC), .IDX_W(IDX_W), .RESET_PQ(RESET_PQ)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .idx(idx), .field_sel(field_sel),
      .cur_pq(cur_pq), .wr_en(wr_en), .wr_pq(nxt_pq)
   );

   esb_pq_alu u_alu (
      .op(op), .cur(cur_pq), .set_val(set_val), .nxt(nxt_pq), .res(res)
   );

   always_comb begin
      en_bit = 1'b0;
      for (int k = 0; k < N_DESC; k++) begin
         if (idx == IDX_W'(k)) en_bit = desc_en[k];
      end
   end

   assign legal = req_valid && !req_write && (req_size == SIZE_8B);
   assign hit   = legal && known && en_bit;
   assign wr_en = hit && (nxt_pq != cur_pq);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !legal;
         rsp_data  <= hit ? {62'b0, res} : '1;
      end
   end

   assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_store_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_err && rsp_data == '1));

   assert_size_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != SIZE_8B) |=> rsp_err);

   assert_no_write_when_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |-> !wr_en);

   assert_result_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_data[63:2] == '0 || rsp_data == '1));

endmodule

// File: tb/tb_esb_page_ctrl.sv
module tb_esb_page_ctrl;
   localparam int AW = 24;
   localparam int N  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [1:0]    req_size = 2'd3;
   logic [AW-1:0] req_addr = '0;
   logic [N-1:0]  desc_en = 4'b1011;
   logic          rsp_valid;
   logic [63:0]   rsp_data;
   logic          rsp_err;

   esb_page_ctrl #(.ADDR_W(AW), .PAGE_SHIFT(12), .N_DESC(N), .RESET_PQ(2'b01)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .desc_en(desc_en),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
   );

   always #5 clk = ~clk;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   int    model [N][2];
   bit    exp_v    = 0;
   bit    exp_err  = 0;
   logic [63:0] exp_data = '0;
   string exp_tag  = "R1";

   function automatic logic [AW-1:0] mk(int idx, int sel, int off);
      return AW'((idx << 13) | (sel << 12) | (off & 'hFFF));
   endfunction

   task automatic check_prev();
      n_checks++;
      if (rsp_valid !== exp_v) begin
         n_fail++;
         $display("FAIL %s: rsp_valid=%0b expected %0b", exp_tag, rsp_valid, exp_v);
      end else if (exp_v && (rsp_data !== exp_data || rsp_err !== exp_err)) begin
         n_fail++;
         $display("FAIL %s: data=%h err=%0b expected data=%h err=%0b",
                  exp_tag, rsp_data, rsp_err, exp_data, exp_err);
      end
   endtask

   // One cycle: check last response, then drive a new request and predict it.
   task automatic step(string tag, bit v, bit w, logic [1:0] sz, logic [AW-1:0] a);
      int idx, sel, off, cur;
      @(negedge clk);
      check_prev();
      req_valid = v; req_write = w; req_size = sz; req_addr = a;
      exp_v = v; exp_err = 0; exp_data = '1; exp_tag = tag;
      if (v) begin
         idx = int'(a >> 13); sel = int'(a[12]); off = int'(a[11:0]);
         if (w || sz != 2'd3) begin
            exp_err = 1;
         end else if (idx < N && desc_en[idx]) begin
            cur = model[idx][sel];
            if (off < 'h800) begin
               exp_data = 64'(cur & 1);
               model[idx][sel] = (cur & 1) ? 2 : 0;
            end else if (off < 'hC00) begin
               exp_data = 64'(cur);
            end else begin
               exp_data = 64'(cur);
               model[idx][sel] = (off >> 8) & 3;
            end
         end
      end
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, 2'd3, '0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         model[i][0] = 1; model[i][1] = 1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1");
      // R1: reset value of every enabled field
      for (int i = 0; i < N; i++) begin
         for (int s = 0; s < 2; s++) step("R1", 1, 0, 2'd3, mk(i, s, 'h800));
      end
      // R5: force values, previous returned
      step("R5", 1, 0, 2'd3, mk(0, 0, 'hF00));
      step("R3", 1, 0, 2'd3, mk(0, 0, 'h9F8));
      // R2: escalation field of the same descriptor untouched
      step("R2", 1, 0, 2'd3, mk(0, 1, 'h800));
      step("R2", 1, 0, 2'd3, mk(0, 1, 'hD00));
      step("R2", 1, 0, 2'd3, mk(0, 0, 'h800));
      // R4: end-of-interrupt with Q=1 then Q=0
      step("R4", 1, 0, 2'd3, mk(0, 0, 'h000));
      step("R4", 1, 0, 2'd3, mk(0, 0, 'h800));
      step("R4", 1, 0, 2'd3, mk(0, 0, 'h7F8));
      step("R4", 1, 0, 2'd3, mk(0, 0, 'h800));
      // R9: back-to-back updates
      step("R9", 1, 0, 2'd3, mk(1, 1, 'hE00));
      step("R9", 1, 0, 2'd3, mk(1, 1, 'hC00));
      step("R9", 1, 0, 2'd3, mk(1, 1, 'hB00));
      idle("R9");
      // R7: store refused and state kept
      step("R7", 1, 1, 2'd3, mk(3, 0, 'hF00));
      step("R7", 1, 0, 2'd3, mk(3, 0, 'h800));
      // R8: wrong size refused and state kept
      step("R8", 1, 0, 2'd2, mk(3, 0, 'hF00));
      step("R8", 1, 0, 2'd0, mk(3, 0, 'h000));
      step("R8", 1, 0, 2'd3, mk(3, 0, 'h800));
      // R6: disabled and unknown descriptors
      step("R6", 1, 0, 2'd3, mk(2, 0, 'hF00));
      step("R6", 1, 0, 2'd3, mk(2, 1, 'h800));
      step("R6", 1, 0, 2'd3, mk(4, 0, 'hC00));
      step("R6", 1, 0, 2'd3, mk(7, 1, 'h000));
      step("R6", 1, 0, 2'd3, mk(3, 0, 'h800));
      // Mixed traffic
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom % 16);
         step("R2", r != 0, r == 1, (r == 2) ? 2'd1 : 2'd3,
              mk(int'($urandom % 6), int'($urandom % 2), int'($urandom % 4096)));
      end
      idle("R9");
      idle("R9");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule